// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the protocol side of a byte-wide serial memory with 2048 locations and an 11-bit address. It watches a two-wire bus (a clock line and an open-drain data line) and oversamples both lines with the system clock. It recognises START and STOP conditions and moves bytes in and out with the most significant bit first. Its register and bus outputs drive the memory array next to it.

The first byte after a START is a command byte. Bit 0 of that byte selects read or write. Bits 6..4 select the device by comparing them with three strap pins. In a write command, bits 3..1 carry the top three address bits. A write command is followed by the low address byte and then by data bytes. Each data byte goes out on a one-cycle write strobe into a page buffer held outside the block. A STOP after at least one data byte pulses the programming request. While the outside array reports that it is busy programming, the engine does not acknowledge command bytes, so a master can poll for completion. Reads return the byte at the internal address counter and then advance the counter. They continue for as long as the master acknowledges.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the engine is idle with the data line released, `mem_we` and `prog_start` low. A START (data falls while the clock is high) in any state restarts command reception. A STOP (data rises while the clock is high) returns the engine to idle and releases the line.
- R2: Bits are sampled on the rising clock edge, most significant bit first. The engine changes its data-line drive only while the synchronised clock is low.
- R3: A command byte is acknowledged only if bit7=1, bit6 equals `cs_pins[2]`, bit5 equals the inverse of `cs_pins[1]` and bit4 equals `cs_pins[0]`. If the byte does not match, it is not acknowledged and nothing is driven until the next START.
- R4: A write command (bit0=0) loads bits 3..1 into address bits 10..8. The next byte is acknowledged and loaded into address bits 7..0.
- R5: Each later byte in a write is acknowledged and presented on `mem_addr`/`mem_wdata` with a one-cycle `mem_we`. After each such byte only address bits 3..0 increment, wrapping inside the 16-byte page. The counter then points past the last byte written in the page.
- R6: A STOP after at least one data byte gives a one-cycle `prog_start`. A STOP with no data byte, or a repeated START, discards the write with no `prog_start`.
- R7: A read command (bit0=1) is acknowledged and then returns the byte at the current counter. The counter advances by one per byte over the full 11-bit range, wrapping from 0x7FF to 0x000.
- R8: While the master acknowledges, the engine sends the next byte. A master no-acknowledge ends the read with the line released until the next START.
- R9: While `busy` is high, a matching command byte is not acknowledged.
- R10: Random read: a write command and address byte, then a repeated START and a read command, return the byte at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| cs_pins | input | 3 | Device select straps |
| busy | input | 1 | Array is in a programming cycle |
| mem_addr | output | 11 | Write address during `mem_we`, otherwise the address counter |
| mem_wdata | output | 8 | Byte for the page buffer |
| mem_we | output | 1 | One-cycle strobe loading `mem_wdata` at `mem_addr` |
| mem_rdata | input | 8 | Array byte at `mem_addr` (combinational) |
| prog_start | output | 1 | One-cycle request to program the buffered page |

## Verification
The assertions assume that the bus follows the two-wire rules: the data line changes while the clock is low, except at START and STOP. They also assume that `busy` rises only after `prog_start`. The bench master holds each clock phase for several system clocks and moves the data line only in the low phase, a few clocks after the falling edge. It drives `busy` from its own array model, which is triggered by `prog_start`. Expected read data comes from a model that the bench updates from the bytes it sends, using the page-wrap rule.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int AW = 11,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [2:0]    cs_pins,
  input  logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  input  logic [7:0]    mem_rdata,
  output logic          prog_start
);
  localparam int HI = AW - 8;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_WDATA, S_RDATA, S_SKIP} st_t;

  logic [1:0] scl_s, sda_s;
  logic scl_q, sda_q;
  logic scl, sda, scl_rise, scl_fall, start_c, stop_c;
  st_t st;
  logic [3:0] bitcnt;
  logic ack_ph, mack, pend;
  logic [7:0] sr, tx;
  logic [AW-1:0] addr, waddr;
  logic sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_q <= scl_s[1];
      sda_q <= sda_s[1];
    end
  end

  assign scl      = scl_s[1];
  assign sda      = sda_s[1];
  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_c  = scl & scl_q & sda_q & ~sda;
  assign stop_c   = scl & scl_q & ~sda_q & sda;

  assign sel = sr[7] & (sr[6] == cs_pins[2]) & (sr[5] == ~cs_pins[1]) & (sr[4] == cs_pins[0]);
  assign mem_addr = mem_we ? waddr : addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      mack <= 1'b0;
      pend <= 1'b0;
      sr <= '0;
      tx <= '0;
      addr <= '0;
      waddr <= '0;
      sda_oe <= 1'b0;
      mem_we <= 1'b0;
      mem_wdata <= '0;
      prog_start <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      prog_start <= 1'b0;
      if (start_c) begin
        st <= S_CMD;
        bitcnt <= '0;
        ack_ph <= 1'b0;
        sda_oe <= 1'b0;
        pend <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE;
        bitcnt <= '0;
        ack_ph <= 1'b0;
        sda_oe <= 1'b0;
        prog_start <= pend;
        pend <= 1'b0;
      end else if (st != S_IDLE && st != S_SKIP) begin
        if (scl_rise) begin
          if (ack_ph) mack <= ~sda;
          else if (bitcnt != 4'd8) begin
            bitcnt <= bitcnt + 4'd1;
            if (st != S_RDATA) sr <= {sr[6:0], sda};
          end
        end else if (scl_fall) begin
          if (st == S_RDATA) begin
            if (ack_ph) begin
              ack_ph <= 1'b0;
              if (mack) begin
                // mack is also set by the engine's own command ack low level
                tx <= {mem_rdata[6:0], 1'b0};
                sda_oe <= ~mem_rdata[7];
                addr <= addr + 1'b1;
                bitcnt <= '0;
              end else begin
                sda_oe <= 1'b0;
                st <= S_SKIP;
              end
            end else if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              ack_ph <= 1'b1;
            end else begin
              sda_oe <= ~tx[7];
              tx <= {tx[6:0], 1'b0};
            end
          end else if (ack_ph) begin
            ack_ph <= 1'b0;
            sda_oe <= 1'b0;
            bitcnt <= '0;
          end else if (bitcnt == 4'd8) begin
            case (st)
              S_CMD: begin
                if (sel && !busy) begin
                  sda_oe <= 1'b1;
                  ack_ph <= 1'b1;
                  if (sr[0]) st <= S_RDATA;
                  else begin
                    addr[AW-1:8] <= sr[HI:1];
                    st <= S_ADDR;
                  end
                end else st <= S_SKIP;
              end
              S_ADDR: begin
                addr[7:0] <= sr;
                sda_oe <= 1'b1;
                ack_ph <= 1'b1;
                st <= S_WDATA;
              end
              S_WDATA: begin
                mem_we <= 1'b1;
                mem_wdata <= sr;
                waddr <= addr;
                addr[PW-1:0] <= addr[PW-1:0] + 1'b1;
                pend <= 1'b1;
                sda_oe <= 1'b1;
                ack_ph <= 1'b1;
              end
              default: st <= S_SKIP;
            endcase
          end
        end
      end
    end
  end

  assert_drive_low_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s[1]);

  assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |-> !sda_oe);

  assert_page_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[AW-1:PW] == addr[AW-1:PW]));

  assert_page_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (addr[PW-1:0] == mem_addr[PW-1:0] + 1'b1));

  assert_prog_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> (st == S_IDLE && !busy));

  assert_busy_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && st != S_RDATA && $past(st) == S_CMD) |-> !$past(busy));
endmodule

// File: tb/i2c_eeprom_slave_tb_top.sv
module i2c_eeprom_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, mem_we, prog_start, busy;
  logic [10:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  localparam logic [2:0] CS = 3'b101;
  wire sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_eeprom_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .cs_pins(CS), .busy(busy), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .prog_start(prog_start));

  logic [7:0] mem [2048];
  logic [7:0] pdat [2048];
  logic       pv [2048];
  logic [7:0] exp_mem [2048];
  int bcnt = 0, pcount = 0;
  logic clr_p = 1'b0;
  int errs = 0, checks = 0;
  logic [10:0] ptr;

  assign busy = (bcnt != 0);
  assign mem_rdata = mem[mem_addr];

  function automatic logic [7:0] init_val(int a);
    return 8'((a * 7 + 3) ^ (a >> 3));
  endfunction

  function automatic logic [7:0] cmd(logic rd, logic [2:0] hi, logic bad);
    return {1'b1, CS[2], ~CS[1] ^ bad, CS[0], hi, rd};
  endfunction

  always @(posedge clk) begin
    if (clr_p) for (int i = 0; i < 2048; i++) pv[i] = 1'b0;
    if (mem_we) begin pv[mem_addr] = 1'b1; pdat[mem_addr] = mem_wdata; end
    if (prog_start) begin
      pcount++;
      for (int i = 0; i < 2048; i++) if (pv[i]) begin mem[i] = pdat[i]; pv[i] = 1'b0; end
      bcnt = 400;
    end else if (bcnt > 0) bcnt--;
  end

  task automatic chk(logic ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic w(int n); repeat (n) @(negedge clk); endtask

  task automatic m_start();
    if (!scl) begin sda_m = 1'b1; w(4); scl = 1'b1; w(6); end
    sda_m = 1'b0; w(6); scl = 1'b0; w(4);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; w(4); scl = 1'b1; w(6); sda_m = 1'b1; w(8);
  endtask

  task automatic m_bit(logic b, output logic s);
    sda_m = b; w(4); scl = 1'b1; w(6); s = sda_line; w(4); scl = 1'b0; w(4);
  endtask

  task automatic m_wbyte(logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(b[i], s);
    m_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic m_rbyte(logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin m_bit(1'b1, s); b = {b[6:0], s}; end
    m_bit(!mack, s);
  endtask

  task automatic do_read(int n);
    logic ack;
    logic [7:0] b;
    m_start();
    m_wbyte(cmd(1'b1, 3'd0, 1'b0), ack);
    chk(ack, "R7 read command ack", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      m_rbyte(i < n - 1, b);
      chk(b == exp_mem[ptr], (i > 0) ? "R8 sequential byte" : "R7 read data", int'(b), int'(exp_mem[ptr]));
      ptr = ptr + 11'd1;
    end
    w(2);
    chk(!sda_oe, "R8 released after no-ack", int'(sda_oe), 0);
    m_stop();
  endtask

  task automatic set_addr(logic [10:0] a);
    logic ack;
    m_start();
    m_wbyte(cmd(1'b0, a[10:8], 1'b0), ack);
    chk(ack, "R4 write command ack", int'(ack), 1);
    m_wbyte(a[7:0], ack);
    chk(ack, "R4 low address ack", int'(ack), 1);
    ptr = a;
  endtask

  task automatic wait_ready();
    logic ack;
    int pc;
    pc = pcount;
    do begin
      m_start();
      m_wbyte(cmd(1'b0, ptr[10:8], 1'b0), ack);
      m_stop();
    end while (!ack);
    chk(pcount == pc, "R6 stop without data", pcount, pc);
  endtask

  task automatic do_write(logic [10:0] a, int n);
    logic ack;
    logic [7:0] d;
    int pc;
    clr_p = 1'b1; w(1); clr_p = 1'b0;
    pc = pcount;
    set_addr(a);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      m_wbyte(d, ack);
      chk(ack, "R5 data ack", int'(ack), 1);
      exp_mem[{a[10:4], 4'(a[3:0] + i)}] = d;
    end
    m_stop();
    w(2);
    chk(pcount == pc + 1, "R6 programming request", pcount, pc + 1);
    ptr = {a[10:4], 4'(a[3:0] + n)};
    m_start();
    m_wbyte(cmd(1'b0, ptr[10:8], 1'b0), ack);
    chk(!ack, "R9 no ack while busy", int'(ack), 0);
    m_stop();
    wait_ready();
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    int pc;
    void'($urandom(32'd2024));
    for (int i = 0; i < 2048; i++) begin
      mem[i] = init_val(i); exp_mem[i] = init_val(i); pv[i] = 1'b0; pdat[i] = '0;
    end
    w(5);
    rst_n = 1'b1;
    w(5);
    chk(!sda_oe && !mem_we && !prog_start, "R1 reset state",
        int'({sda_oe, mem_we, prog_start}), 0);
    ptr = 11'd0;

    // R3: wrong select, then traffic ignored
    m_start();
    m_wbyte(cmd(1'b0, 3'd5, 1'b1), ack);
    chk(!ack, "R3 wrong select no ack", int'(ack), 0);
    m_wbyte(8'h00, ack);
    chk(!ack, "R3 ignored until START", int'(ack), 0);
    m_stop();
    do_read(2);

    // R10: random read via repeated START
    set_addr(11'h2A5);
    do_read(3);

    // R7: rollover at top of range
    set_addr(11'h7FE);
    do_read(4);
    chk(ptr == 11'h002, "R7 counter wrapped", int'(ptr), 2);

    // R6: abandoned write with data, and STOP right after address
    pc = pcount;
    clr_p = 1'b1; w(1); clr_p = 1'b0;
    set_addr(11'h130);
    m_wbyte(8'hEE, ack);
    chk(ack, "R5 data ack", int'(ack), 1);
    ptr = 11'h131;
    do_read(1);
    chk(pcount == pc, "R6 repeated START discards", pcount, pc);
    set_addr(11'h130);
    m_stop();
    w(2);
    chk(pcount == pc, "R6 STOP after address only", pcount, pc);
    ptr = 11'h130;
    do_read(2);

    // R1: START mid-byte restarts command reception
    m_start();
    m_wbyte(cmd(1'b0, 3'd0, 1'b0), ack);
    sda_m = 1'b1; w(4); scl = 1'b1; w(6); scl = 1'b0; w(4);
    ptr = {3'd0, 8'(ptr)};
    do_read(1);
    chk(1'b1, "R1 restart accepted", 0, 0);

    // R5: page wrap with 20 bytes
    do_write(11'h1F3, 20);
    do_read(3);
    ptr = 11'h1F0;
    set_addr(11'h1F0);
    do_read(16);

    // random mix
    for (int k = 0; k < 8; k++) begin
      logic [10:0] a;
      int n;
      a = 11'($urandom);
      n = 1 + int'($urandom % 18);
      do_write(a, n);
      set_addr(11'($urandom));
      do_read(1 + int'($urandom % 8));
    end
    do_read(2);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule